// File: doc/BRIEF.md
# Bit-Plane 2x2 Edge Extractor

This block turns a raster stream of grayscale pixels into a binary edge map without any gradient arithmetic. Every pixel word is treated as a stack of bit-planes. For each plane a 2x2 window slides across the image, and a plane reports an edge at a window position when its four bits are not all equal. The per-plane results of the top planes, counted down from the most significant bit, are merged with a logical OR into one edge bit.

Pixels arrive one per clock when `pix_valid` is high, in row-major order, with `pix_sof` marking the first pixel of a frame. The image size is set by parameters. One row of pixel words is held in a line store so that the window can be formed from the row above. An image of H rows by W columns yields (H-1) x (W-1) edge bits, one per accepted pixel from the second row and second column onward. The number of planes to merge is a runtime input. One plane (MSB only) is the usual setting because the lower planes carry mostly noise.

Top module: `bitplane_edge_extractor`

## Requirements
- R1: For an accepted pixel at row r, column c (both counted from 0 within the frame), `edge_valid` is high in the cycle after acceptance exactly when r >= 1 and c >= 1, so a frame of IMG_H x IMG_W pixels gives (IMG_H-1) x (IMG_W-1) valid edge bits. The edge bit belongs to the window made of pixels (r-1,c-1), (r-1,c), (r,c-1) and (r,c).
- R2: For a single plane, the window result is 0 when its four bits are all 0 or all 1, and 1 for every other combination (one to three ones).
- R3: With p planes selected, the planes merged are bit positions PIX_W-1 down to PIX_W-p of the pixel word, and `edge_bit` is the OR of their window results. Lower planes have no effect.
- R4: `planes_sel` is an unsigned count. A value of 0 acts as 1, and a value above PIX_W acts as PIX_W. It applies to the pixel accepted in the same cycle.
- R5: A pixel accepted with `pix_sof` high takes position (0,0), even in the middle of a frame. Counting of rows and columns restarts from it.
- R6: A cycle with `pix_valid` low accepts nothing and produces `edge_valid` low in the next cycle. The raster position and the stored rows are kept, so the stream resumes where it stopped.
- R7: After reset `edge_valid` and `edge_bit` are 0.
- R8: `edge_bit` is 0 whenever `edge_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pix_valid | input | 1 | A pixel is presented this cycle |
| pix_sof | input | 1 | The presented pixel is the first of a frame |
| pix_data | input | PIX_W | Grayscale pixel word, bit PIX_W-1 is the most significant plane |
| planes_sel | input | SEL_W | Number of top planes to merge (clamped to 1..PIX_W) |
| edge_valid | output | 1 | `edge_bit` holds a map pixel |
| edge_bit | output | 1 | Merged edge decision for the window ending at the previous accepted pixel |

## Verification
The stream is driven with a flat black frame, which must give no edges at all, and a checkerboard on the top plane, which must mark every window. A frame in which only the second plane varies separates a one-plane setting from a two-plane setting, and random frames under several plane counts, including the out-of-range counts 0 and 15, check the merge and the clamping. Frames with idle gaps in the stream and a frame restarted by a start marker in the middle of a row show that the position counting survives stalls and resynchronises to the marker.

// File: rtl/ebx_pkg.sv
package ebx_pkg;

  // Window decision for one plane: 1 unless the four bits agree.
  function automatic logic quad_edge(input logic [3:0] quad);
    return (|quad) & ~(&quad);
  endfunction

endpackage

// File: rtl/ebx_raster_pos.sv
module ebx_raster_pos #(
  parameter int IMG_W = 512,
  parameter int IMG_H = 512,
  localparam int COL_W = (IMG_W > 1) ? $clog2(IMG_W) : 1,
  localparam int ROW_W = (IMG_H > 1) ? $clog2(IMG_H) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             restart,
  output logic [COL_W-1:0] pos_col,
  output logic [ROW_W-1:0] pos_row,
  output logic             win_ok
);

  localparam logic [COL_W-1:0] COL_LAST = COL_W'(IMG_W - 1);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(IMG_H - 1);

  logic [COL_W-1:0] col_q, col_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic             last_col, last_row;

  always_comb begin
    pos_col  = restart ? '0 : col_q;
    pos_row  = restart ? '0 : row_q;
    last_col = (pos_col == COL_LAST);
    last_row = (pos_row == ROW_LAST);
    win_ok   = (pos_col != '0) && (pos_row != '0);
    col_d    = col_q;
    row_d    = row_q;
    if (step) begin
      col_d = last_col ? '0 : pos_col + COL_W'(1);
      if (last_col) begin
        row_d = last_row ? '0 : pos_row + ROW_W'(1);
      end else begin
        row_d = pos_row;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
      row_q <= '0;
    end else if (step) begin
      col_q <= col_d;
      row_q <= row_d;
    end
  end

  AST_COL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    col_q <= COL_LAST);  // R1
  AST_ROW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    row_q <= ROW_LAST);  // R1
  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> ($stable(col_q) && $stable(row_q)));  // R6
  AST_SOF_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (step && restart) |=> (row_q == '0 || IMG_W == 1));  // R5

endmodule

// File: rtl/ebx_row_store.sv
module ebx_row_store #(
  parameter int DEPTH = 512,
  parameter int DW    = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  // Read returns the word stored one row earlier; the write lands at the edge.
  always_comb rdata = mem[addr];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[addr] <= wdata;
    end
  end

  AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(addr) < DEPTH));  // R1

endmodule

// File: rtl/ebx_plane_gate.sv
module ebx_plane_gate #(
  parameter int PIX_W = 8,
  parameter int SEL_W = $clog2(PIX_W + 1)
) (
  input  logic [SEL_W-1:0] planes_sel,
  output logic [PIX_W-1:0] plane_mask
);

  int unsigned cnt;
  logic [PIX_W-1:0] below;

  always_comb begin
    if (planes_sel == '0) begin
      cnt = 1;
    end else if (int'(planes_sel) > PIX_W) begin
      cnt = PIX_W;
    end else begin
      cnt = int'(planes_sel);
    end
  end

  for (genvar k = 0; k < PIX_W; k++) begin : g_bit
    assign plane_mask[k] = ((k + int'(cnt)) >= PIX_W);
  end

  always_comb begin
    below = ~plane_mask;
    AST_MASK_HAS_MSB: assert (plane_mask[PIX_W-1]);  // R4
    AST_MASK_CONTIG: assert ((below & (below + PIX_W'(1))) == '0);  // R3
  end

endmodule

// File: rtl/bitplane_edge_extractor.sv
module bitplane_edge_extractor #(
  parameter int IMG_W = 512,
  parameter int IMG_H = 512,
  parameter int PIX_W = 8,
  parameter int SEL_W = $clog2(PIX_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_valid,
  input  logic             pix_sof,
  input  logic [PIX_W-1:0] pix_data,
  input  logic [SEL_W-1:0] planes_sel,
  output logic             edge_valid,
  output logic             edge_bit
);

  import ebx_pkg::*;

  localparam int COL_W = (IMG_W > 1) ? $clog2(IMG_W) : 1;
  localparam int ROW_W = (IMG_H > 1) ? $clog2(IMG_H) : 1;

  // Reset: asserted at once, released after two clock edges.
  logic [1:0] rst_pipe_q;
  logic       rst_ok_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_ok_n = rst_pipe_q[1];

  logic [COL_W-1:0] pos_col;
  logic [ROW_W-1:0] pos_row;
  logic             win_ok;
  logic [PIX_W-1:0] up_word;
  logic [PIX_W-1:0] plane_mask;

  ebx_raster_pos #(.IMG_W(IMG_W), .IMG_H(IMG_H)) pos_i (
    .clk     (clk),
    .rst_n   (rst_ok_n),
    .step    (pix_valid),
    .restart (pix_sof),
    .pos_col (pos_col),
    .pos_row (pos_row),
    .win_ok  (win_ok)
  );

  ebx_row_store #(.DEPTH(IMG_W), .DW(PIX_W)) rows_i (
    .clk   (clk),
    .rst_n (rst_ok_n),
    .wr_en (pix_valid),
    .addr  (pos_col),
    .wdata (pix_data),
    .rdata (up_word)
  );

  ebx_plane_gate #(.PIX_W(PIX_W), .SEL_W(SEL_W)) gate_i (
    .planes_sel (planes_sel),
    .plane_mask (plane_mask)
  );

  logic [PIX_W-1:0] left_q, left_d;
  logic [PIX_W-1:0] upleft_q, upleft_d;
  logic [PIX_W-1:0] plane_hit;
  logic             valid_q, valid_d;
  logic             bit_q, bit_d;

  for (genvar k = 0; k < PIX_W; k++) begin : g_plane
    assign plane_hit[k] = plane_mask[k] &
      quad_edge({upleft_q[k], up_word[k], left_q[k], pix_data[k]});
  end

  always_comb begin
    left_d   = left_q;
    upleft_d = upleft_q;
    valid_d  = 1'b0;
    bit_d    = 1'b0;
    if (pix_valid) begin
      left_d   = pix_data;
      upleft_d = up_word;
      valid_d  = win_ok;
      bit_d    = win_ok & (|plane_hit);
    end
  end

  always_ff @(posedge clk or negedge rst_ok_n) begin
    if (!rst_ok_n) begin
      left_q   <= '0;
      upleft_q <= '0;
      valid_q  <= 1'b0;
      bit_q    <= 1'b0;
    end else begin
      if (pix_valid) begin
        left_q   <= left_d;
        upleft_q <= upleft_d;
      end
      valid_q <= valid_d;
      bit_q   <= bit_d;
    end
  end

  assign edge_valid = valid_q;
  assign edge_bit   = bit_q;

  AST_BIT_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !edge_valid |-> !edge_bit);  // R8
  AST_VALID_NEEDS_PIXEL: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !pix_valid |=> !edge_valid);  // R6
  AST_NO_VALID_ON_SOF: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (pix_valid && pix_sof) |=> !edge_valid);  // R5
  AST_FIRST_COL_SILENT: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (pix_valid && pos_col == '0) |=> !edge_valid);  // R1

endmodule

// File: tb/bitplane_edge_extractor_tb_top.sv
module bitplane_edge_extractor_tb_top;

  localparam int TW = 6;
  localparam int TH = 5;
  localparam int PW = 8;
  localparam int SW = $clog2(PW + 1);

  logic          clk;
  logic          rst_n;
  logic          pix_valid;
  logic          pix_sof;
  logic [PW-1:0] pix_data;
  logic [SW-1:0] planes_sel;
  logic          edge_valid;
  logic          edge_bit;

  int total_checks;
  int bad_checks;
  bit finished;

  int img [TH][TW];
  int mrow;
  int mcol;

  bitplane_edge_extractor #(.IMG_W(TW), .IMG_H(TH), .PIX_W(PW)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .pix_valid  (pix_valid),
    .pix_sof    (pix_sof),
    .pix_data   (pix_data),
    .planes_sel (planes_sel),
    .edge_valid (edge_valid),
    .edge_bit   (edge_bit)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic report_end();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total_checks, bad_checks);
      $finish;
    end
  endtask

  initial begin
    for (int n = 0; n < 100000; n++) @(posedge clk);
    total_checks++;
    bad_checks++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    report_end();
  end

  task automatic check(input string tag, input logic act, input logic exp, input string what);
    total_checks++;
    if (act !== exp) begin
      bad_checks++;
      $display("FAIL %s %s: actual=%0b expected=%0b (row %0d col %0d)",
               tag, what, act, exp, mrow, mcol);
    end
  endtask

  function automatic int clamp_p(input int p);
    if (p == 0) return 1;
    if (p > PW) return PW;
    return p;
  endfunction

  // One clock: drive, model, then compare the registered outputs.
  task automatic drive(input bit v, input bit sof, input int data, input int p, input string tag);
    bit ev;
    bit eb;
    int pc;
    @(negedge clk);
    pix_valid  = v;
    pix_sof    = sof;
    pix_data   = PW'(data);
    planes_sel = SW'(p);
    ev = 1'b0;
    eb = 1'b0;
    if (v) begin
      if (sof) begin
        mrow = 0;
        mcol = 0;
      end
      img[mrow][mcol] = data;
      ev = (mrow >= 1) && (mcol >= 1);
      if (ev) begin
        pc = clamp_p(p);
        for (int k = PW - 1; k >= PW - pc; k--) begin
          int s;
          s = ((img[mrow-1][mcol-1] >> k) & 1) + ((img[mrow-1][mcol] >> k) & 1)
            + ((img[mrow][mcol-1] >> k) & 1) + ((data >> k) & 1);
          if (s >= 1 && s <= 3) eb = 1'b1;
        end
      end
    end
    @(posedge clk);
    #1;
    check(v ? "R1" : "R6", edge_valid, ev, "edge_valid");
    check(ev ? tag : "R8", edge_bit, eb, "edge_bit");
    if (v) begin
      mcol++;
      if (mcol == TW) begin
        mcol = 0;
        mrow++;
        if (mrow == TH) mrow = 0;
      end
    end
  endtask

  function automatic int pattern(input int id, input int r, input int c);
    case (id)
      0: return 0;
      1: return (((r + c) % 2) == 1) ? 8'h80 : 8'h00;
      2: return ((c % 2) == 1) ? 8'hC0 : 8'h80;
      3: return (r == 2 && c == 3) ? 8'h00 : 8'hFF;
      default: return int'($urandom_range(255, 0));
    endcase
  endfunction

  task automatic frame(input int id, input int p, input int gap, input string tag);
    for (int r = 0; r < TH; r++) begin
      for (int c = 0; c < TW; c++) begin
        if (gap != 0 && ((r * TW + c) % gap) == 1) drive(1'b0, 1'b0, 8'h5A, p, "R6");
        drive(1'b1, (r == 0 && c == 0), pattern(id, r, c), p, tag);
      end
    end
  endtask

  initial begin
    total_checks = 0;
    bad_checks   = 0;
    finished     = 1'b0;
    mrow = 0;
    mcol = 0;
    rst_n      = 1'b0;
    pix_valid  = 1'b0;
    pix_sof    = 1'b0;
    pix_data   = '0;
    planes_sel = SW'(1);
    repeat (3) @(posedge clk);
    #1;
    check("R7", edge_valid, 1'b0, "edge_valid in reset");
    check("R7", edge_bit, 1'b0, "edge_bit in reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check("R7", edge_valid, 1'b0, "edge_valid after reset");

    frame(0, 1, 0, "R2");      // flat: no edges
    frame(1, 1, 0, "R2");      // MSB checkerboard: every window marked
    frame(3, 1, 0, "R2");      // single dark pixel: local edges only
    frame(2, 1, 0, "R3");      // only plane 6 varies: one plane sees nothing
    frame(2, 2, 0, "R3");      // two planes see the variation
    frame(4, 0, 0, "R4");      // count 0 acts as 1
    frame(4, 15, 0, "R4");     // count above width acts as full width
    frame(4, 8, 0, "R3");
    frame(4, 3, 0, "R3");
    frame(4, 2, 3, "R6");      // stalls inside the frame

    // Mid-frame restart: a partial row, then a marker starts a new frame.
    for (int c = 0; c < TW + 2; c++) drive(1'b1, (c == 0), pattern(4, 0, c), 4, "R5");
    frame(4, 4, 0, "R5");
    frame(1, 1, 5, "R5");

    repeat (2) drive(1'b0, 1'b0, 0, 1, "R6");
    report_end();
  end

endmodule